// File: doc/BRIEF.md
# Pipelined No-Wait Burst SRAM

A synchronous single-port static RAM that accepts one command on every enabled clock: a read, a write or a deselect. It never needs a dead cycle when the data bus turns around. All inputs are registered on the rising edge. Read data leaves the block two enabled edges after its address is taken. Write data is taken at the same pipeline depth, so a read and a write always occupy the bus in the same relative slot. Reads and writes can therefore alternate at full bus use.

A 2-bit burst counter lets a single loaded address drive four accesses. The order is linear or interleaved, chosen by `burst_ilv`. Per-lane write strobes mask individual byte lanes. An active-low clock enable freezes every register in the block. Three chip enables must all be active for a load to select the device; otherwise the load is a deselect.

The burst controller is a three-state machine:
- `ST_DESEL`: no access.
- `ST_READ`: read burst in progress.
- `ST_WRITE`: write burst in progress.

Its transitions are:
- `LOAD_DESEL`: a load while not selected, entering `ST_DESEL` from any state.
- `LOAD_READ`: a selected load with `we_n` high, entering `ST_READ`.
- `LOAD_WRITE`: a selected load with `we_n` low, entering `ST_WRITE`.
- `ADVANCE`: `adv` high, which keeps the state and steps the counter (no step in `ST_DESEL`).
- `FREEZE`: `cen_n` high, which holds everything.

Top module: `nws_sram`

## Requirements
- R1: After reset, `rdata_oe` is low until a read result is delivered.
- R2: A read accepted at enabled edge E drives its data and `rdata_oe` high right after enabled edge E+2.
- R3: A write accepted at enabled edge E takes `wdata` at enabled edge E+2. Lane i (bits i*9 to i*9+8) is stored only if `bw_n[i]` is 0 at that edge.
- R4: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued right after a write to the same address returns the new data.
- R5: `adv`=0 loads a new address and command. `adv`=1 continues the previous command type at the next burst address.
- R6: With `burst_ilv`=0, beat k of a burst uses low address bits (base+k) mod 4, with the upper address bits unchanged.
- R7: With `burst_ilv`=1, beat k uses low address bits base XOR k.
- R8: The counter is 2 bits wide, so the fifth beat of a burst reuses the start address.
- R9: While `cen_n` is 1, all inputs are ignored and every register, including the outputs, holds its value.
- R10: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A load without selection, and any advance after it, makes no write, no read and no output drive.
- R11: `rdata_oe` is high only in cycles carrying read data. It is low in write-data cycles and deselect cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable; high freezes the block |
| adv | input | 1 | 1 = advance burst, 0 = load new address/command |
| we_n | input | 1 | Active-low write select on a load |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| burst_ilv | input | 1 | 1 = interleaved burst order, 0 = linear |
| addr | input | ADDR_W | Load address |
| bw_n | input | LANES | Active-low lane write strobes, taken with write data |
| wdata | input | DATA_W | Write data, taken two enabled edges after the write command |
| rdata | output | DATA_W | Read data |
| rdata_oe | output | 1 | Output drive enable; high only while rdata is valid |

## Verification
Every result falls due a fixed number of enabled edges after its command, whether it is read data with its drive enable or the sampling of write data. A command driven before enabled edge E shows its read result at the first falling edge after edge E+2, and its write data must be on the pins before that same edge E+2. The bench keeps a queue indexed by enabled-edge number. It drives write data from that queue and computes each read's expected word when that word's edge comes round. It samples on every falling edge against the entry of the most recent enabled edge, so frozen cycles must reproduce the previous outputs exactly.

// File: rtl/nws_pkg.sv
package nws_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } burst_st_e;

    // Low two address bits for burst beat 'step' from start 'base'.
    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (base ^ step) : (base + step);
    endfunction

endpackage

// File: rtl/nws_burst.sv
module nws_burst #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic              sel,
    input  logic              ilv,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr
);
    import nws_pkg::*;

    burst_st_e         st_q, st_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic [1:0]        cnt_q, cnt_d;

    // State register: frozen while the clock enable is off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_DESEL;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!cen_n) begin
            st_q   <= st_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end

    // Next state: load transitions or advance.
    always_comb begin
        st_d   = st_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        if (!adv) begin
            base_d = addr;
            cnt_d  = '0;
            if (!sel)      st_d = ST_DESEL;
            else if (we_n) st_d = ST_READ;
            else           st_d = ST_WRITE;
        end else if (st_q != ST_DESEL) begin
            cnt_d = cnt_q + 2'd1;
        end
    end

    // Outputs: the command issued into the pipeline this cycle.
    always_comb begin
        cmd_addr = {base_d[ADDR_W-1:2], burst_low(base_d[1:0], cnt_d, ilv)};
        unique case (st_d)
            ST_READ:  begin cmd_valid = 1'b1; cmd_wr = 1'b0; end
            ST_WRITE: begin cmd_valid = 1'b1; cmd_wr = 1'b1; end
            default:  begin cmd_valid = 1'b0; cmd_wr = 1'b0; end
        endcase
    end

    assert_unselected_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !adv && !sel) |=> (st_q == ST_DESEL));

    assert_advance_keeps_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && adv) |=> (st_q == $past(st_q)));

    assert_burst_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(st_q) && $stable(base_q) && $stable(cnt_q)));

endmodule

// File: rtl/nws_pipe.sv
module nws_pipe #(
    parameter int ADDR_W = 6,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              in_v,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              x_v,
    output logic              x_wr,
    output logic [ADDR_W-1:0] x_addr
);
    logic [LAT-1:0]    v_q, w_q;
    logic [ADDR_W-1:0] a_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= '0;
            w_q <= '0;
            for (int i = 0; i < LAT; i++) a_q[i] <= '0;
        end else if (!cen_n) begin
            v_q <= {v_q[LAT-2:0], in_v};
            w_q <= {w_q[LAT-2:0], in_wr};
            a_q[0] <= in_addr;
            for (int i = 1; i < LAT; i++) a_q[i] <= a_q[i-1];
        end
    end

    assign x_v    = v_q[LAT-1];
    assign x_wr   = w_q[LAT-1];
    assign x_addr = a_q[LAT-1];

    assert_pipe_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(v_q) && $stable(w_q)));

    assert_first_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cen_n |=> (v_q[0] == $past(in_v)));

endmodule

// File: rtl/nws_core.sv
module nws_core #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              x_v,
    input  logic              x_wr,
    input  logic [ADDR_W-1:0] x_addr,
    input  logic [LANES-1:0]  bw_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_q;
    logic              oe_q;

    // Write stage: data arrives at the same depth as a read result.
    always_ff @(posedge clk) begin
        if (!cen_n && x_v && x_wr) begin
            for (int l = 0; l < LANES; l++) begin
                if (!bw_n[l]) mem[x_addr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
            end
        end
    end

    // Read stage: all earlier writes have already committed here.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
            oe_q <= 1'b0;
        end else if (!cen_n) begin
            oe_q <= x_v && !x_wr;
            if (x_v && !x_wr) rd_q <= mem[x_addr];
        end
    end

    assign rdata    = rd_q;
    assign rdata_oe = oe_q;

    assert_drive_only_reads_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cen_n |=> (rdata_oe == ($past(x_v) && !$past(x_wr))));

    assert_output_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> ($stable(rdata_oe) && $stable(rdata)));

endmodule

// File: rtl/nws_sram.sv
module nws_sram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 18,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              adv,
    input  logic              we_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  bw_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);
    localparam int LAT = 2;

    logic              sel;
    logic              cmd_v, cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic              x_v, x_wr;
    logic [ADDR_W-1:0] x_addr;

    assign sel = !ce1_n && ce2 && !ce3_n;

    nws_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv(adv), .we_n(we_n),
        .sel(sel), .ilv(burst_ilv), .addr(addr),
        .cmd_valid(cmd_v), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr)
    );

    nws_pipe #(.ADDR_W(ADDR_W), .LAT(LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n),
        .in_v(cmd_v), .in_wr(cmd_wr), .in_addr(cmd_addr),
        .x_v(x_v), .x_wr(x_wr), .x_addr(x_addr)
    );

    nws_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_core (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n),
        .x_v(x_v), .x_wr(x_wr), .x_addr(x_addr),
        .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

endmodule

// File: tb/nws_sram_bench.sv
module nws_sram_bench;
    localparam int AW = 6;
    localparam int DW = 18;
    localparam int NL = 2;
    localparam int LW = DW / NL;
    localparam int QN = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b0, adv = 1'b0, we_n = 1'b1;
    logic          ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0, burst_ilv = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] bw_n = '1;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    always #5 clk = ~clk;

    nws_sram #(.ADDR_W(AW), .DATA_W(DW), .LANES(NL)) u_nws_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv(adv), .we_n(we_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .burst_ilv(burst_ilv),
        .addr(addr), .bw_n(bw_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    int n_chk = 0, n_bad = 0;
    int e = 0, lastx = -1;
    bit prev_stall = 0;
    bit ilv = 0;

    bit            pend_v  [QN];
    bit            pend_wr [QN];
    logic [AW-1:0] pend_a  [QN];
    logic [DW-1:0] pend_d  [QN];
    logic [NL-1:0] pend_bw [QN];
    int            pend_rq [QN];
    bit            exp_oe  [QN];
    logic [DW-1:0] exp_d   [QN];
    int            exp_rq  [QN];
    logic [DW-1:0] mdl     [1<<AW];

    int            b_type = 0;
    logic [AW-1:0] b_base = '0;
    logic [1:0]    b_cnt = '0;

    task automatic chk(input bit ok, input int rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h at enabled edge %0d", rq, act, exp, lastx);
        end
    endtask

    // One clock: check outputs from the last enabled edge, then drive.
    task automatic cyc(input bit cn, input bit ad, input bit we, input bit c1n, input bit c2v,
                       input bit c3n, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic [NL-1:0] bw, input int rq);
        bit eoe;
        int erq;
        logic [AW-1:0] eff;
        @(negedge clk);
        eoe = (lastx < 0) ? 1'b0 : exp_oe[lastx];
        erq = (lastx < 0) ? 1 : exp_rq[lastx];   // R1 before any result
        if (prev_stall) erq = 9;                  // R9 frozen outputs
        chk(rdata_oe === eoe, erq, {17'd0, rdata_oe}, {17'd0, eoe});
        if (eoe) chk(rdata === exp_d[lastx], erq, rdata, exp_d[lastx]);
        if (cn) begin
            // R9: garbage write load while frozen must be ignored
            cen_n = 1'b1; adv = 1'b0; we_n = 1'b0; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
            addr = AW'($urandom); wdata = DW'($urandom); bw_n = '0;
            prev_stall = 1;
            return;
        end
        prev_stall = 0;
        cen_n = 1'b0;
        if (pend_v[e] && pend_wr[e]) begin
            wdata = pend_d[e]; bw_n = pend_bw[e];
            for (int l = 0; l < NL; l++)
                if (!pend_bw[e][l]) mdl[pend_a[e]][l*LW +: LW] = pend_d[e][l*LW +: LW];
        end else begin
            wdata = DW'($urandom); bw_n = '0;
        end
        exp_oe[e] = pend_v[e] && !pend_wr[e];
        if (exp_oe[e]) exp_d[e] = mdl[pend_a[e]];
        exp_rq[e] = (pend_rq[e] != 0) ? pend_rq[e] : 11;
        if (!ad) begin
            b_type = (!c1n && c2v && !c3n) ? (we ? 1 : 2) : 0;
            b_base = a; b_cnt = 2'd0;
        end else if (b_type != 0) begin
            b_cnt = b_cnt + 2'd1;
        end
        eff = {b_base[AW-1:2], ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
        pend_v[e+2]  = (b_type != 0);
        pend_wr[e+2] = (b_type == 2);
        pend_a[e+2]  = eff;
        pend_d[e+2]  = d;
        pend_bw[e+2] = bw;
        pend_rq[e+2] = rq;
        adv = ad; we_n = we; ce1_n = c1n; ce2 = c2v; ce3_n = c3n;
        addr = a; burst_ilv = ilv;
        lastx = e;
        e++;
    endtask

    task automatic ld_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NL-1:0] bw, input int rq);
        cyc(0, 0, 0, 0, 1, 0, a, d, bw, rq);
    endtask
    task automatic ld_rd(input logic [AW-1:0] a, input int rq);
        cyc(0, 0, 1, 0, 1, 0, a, '0, '0, rq);
    endtask
    task automatic step(input logic [DW-1:0] d, input int rq);
        cyc(0, 1, 1, 0, 1, 0, '0, d, '0, rq);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 1, 1, 0, '0, '0, '0, 11); // R11 deselect
    endtask
    task automatic stall();
        cyc(1, 0, 0, 0, 1, 0, '0, '0, '0, 9);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(rdata_oe === 1'b0, 1, {17'd0, rdata_oe}, '0); // R1
        idle(2);
    endtask

    task automatic t_linear();   // R6, R5, R3
        ilv = 0;
        ld_wr(6'h0A, 18'h10A0A, 2'b00, 6);
        step(18'h10B0B, 6); step(18'h10808, 6); step(18'h10909, 6);
        ilv = 1;   // single loads ignore the order
        ld_rd(6'h08, 6); ld_rd(6'h09, 6); ld_rd(6'h0A, 6); ld_rd(6'h0B, 6);
        ilv = 0;
        ld_rd(6'h0A, 5); step('0, 5); step('0, 5); step('0, 5); // R5 read burst
        idle(2);
    endtask

    task automatic t_interleave(); // R7
        ilv = 1;
        ld_wr(6'h15, 18'h21515, 2'b00, 7);
        step(18'h21414, 7); step(18'h21717, 7); step(18'h21616, 7);
        ilv = 0;
        ld_rd(6'h14, 7); ld_rd(6'h15, 7); ld_rd(6'h16, 7); ld_rd(6'h17, 7);
        idle(2);
    endtask

    task automatic t_wrap();     // R8
        ilv = 0;
        ld_wr(6'h22, 18'h00111, 2'b00, 8);
        step(18'h00222, 8); step(18'h00333, 8); step(18'h00444, 8); step(18'h00555, 8);
        ld_rd(6'h22, 8); ld_rd(6'h23, 8);
        idle(2);
    endtask

    task automatic t_turn();     // R4, R2
        ld_wr(6'h30, 18'h0AAAA, 2'b00, 4);
        ld_rd(6'h30, 4);
        ld_wr(6'h31, 18'h15555, 2'b00, 4);
        ld_rd(6'h31, 4);
        ld_rd(6'h30, 2);
        ld_wr(6'h30, 18'h3C3C3, 2'b00, 4);
        ld_rd(6'h30, 4);
        idle(3);
    endtask

    task automatic t_bytes();    // R3
        ld_wr(6'h33, 18'h00000, 2'b00, 3);
        ld_wr(6'h33, 18'h3FFFF, 2'b10, 3); // lane 0 only
        ld_rd(6'h33, 3);
        ld_wr(6'h33, 18'h2AAAA, 2'b01, 3); // lane 1 only
        ld_wr(6'h33, 18'h12345, 2'b11, 3); // no lane
        ld_rd(6'h33, 3);
        idle(2);
    endtask

    task automatic t_stall();    // R9
        ld_wr(6'h38, 18'h0F0F0, 2'b00, 9);
        stall(); stall();
        ld_rd(6'h38, 9);
        stall();
        idle(1);
        stall(); stall();
        idle(1);
        stall();
        ld_rd(6'h38, 9);
        idle(3);
    endtask

    task automatic t_desel();    // R10
        ld_wr(6'h3C, 18'h1CCCC, 2'b00, 10);
        cyc(0, 0, 0, 1, 1, 0, 6'h3C, 18'h00001, 2'b00, 10);
        cyc(0, 1, 0, 1, 1, 0, 6'h3C, 18'h00002, 2'b00, 10);
        cyc(0, 0, 0, 0, 0, 0, 6'h3C, 18'h00003, 2'b00, 10);
        cyc(0, 1, 0, 0, 0, 0, 6'h3C, 18'h00004, 2'b00, 10);
        cyc(0, 0, 1, 0, 1, 1, 6'h3D, 18'h00005, 2'b00, 10); // read while deselected
        cyc(0, 1, 1, 0, 1, 1, 6'h3D, 18'h00006, 2'b00, 10);
        ld_rd(6'h3C, 10);
        ld_rd(6'h3D, 10);
        idle(3);
    endtask

    initial begin
        mdl[6'h3D] = 18'h05A5A;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        ld_wr(6'h3D, 18'h05A5A, 2'b00, 10);
        idle(2);
        t_linear();
        t_interleave();
        t_wrap();
        t_turn();
        t_bytes();
        t_stall();
        t_desel();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule